// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block keeps the global control bits and the interrupt bookkeeping of a two-channel display timing controller. Each timing generator sends a one-cycle pulse when its vertical blank begins, and channel 1 also reports the number of the line it is scanning. The block records each event in a sticky status flag, masks the flags with per-source enable bits and drives a single level-sensitive interrupt line toward the processor.

Software reaches the block through a plain word-wide register port: a byte address, a write strobe, write data and combinational read data. Three words are mapped: a control word at 0x00 whose bits go straight out to the timing logic, an interrupt word at 0x04 that holds enables and status flags side by side, and a line-number word at 0x08. A status flag is cleared by writing 0 to its bit and kept by writing 1, so a handler can read the interrupt word, drop one flag and write the word back without disturbing the enables or the other flags. A third interrupt source fires when the channel 1 line count reaches the programmed line number.

Top module: `disp_irq_ctrl`

## Requirements
- R1: The control word at address 0x00 stores bit 31 (timing enable), bit 30 (gamma enable) and bit 0 (output map select); each stored bit drives its own output pin, and the word reads back with all other bits zero.
- R2: A pulse on vertical-blank input 0 sets status flag bit 15 of the word at 0x04, and a pulse on input 1 sets flag bit 14, at the next clock edge, whether or not the matching enable is set.
- R3: A write to 0x04 loads the enables directly (bit 31 for channel 0, bit 30 for channel 1, bit 29 for line match); for each flag bit, a written 0 clears the flag and a written 1 leaves it as it was.
- R4: When a set event and a write that clears the same flag fall in the same cycle, the flag ends up set.
- R5: The interrupt output is registered: it equals the OR over the three sources of (flag AND enable) as held in the registers one cycle earlier.
- R6: Writing the value zero to 0x04 clears every enable and flag, and the interrupt output stays low afterwards even when further events set flags.
- R7: The word at 0x08 holds a 12-bit line number in bits 11:0; in the first cycle that the line count input equals it, status flag bit 13 is set at the next edge, and it is not set again until the count has left and come back to that value.
- R8: All registers are zero after a synchronous active-low reset; reserved bits and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wr_en | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| vblank_start | input | 2 | One-cycle vertical-blank start pulse per channel |
| line_count | input | 12 | Current line of channel 1 |
| irq | output | 1 | Level interrupt request |
| tc_enable | output | 1 | Stored timing enable bit |
| tc_gamma_en | output | 1 | Stored gamma enable bit |
| tc_map_sel | output | 1 | Stored output map select bit |

## Verification
Flags are first raised with their enables off, which separates the sticky status path from the interrupt mask, and then enabled so the one-cycle delay of the interrupt line is visible. Read-modify-write patterns that write 1 to a set flag and 0 to another show the keep and clear rules apart, while a pulse landing in the same cycle as a clearing write tells set-priority from clear-priority. The line count is ramped through the programmed value, held on it across a clearing write, and then moved away and back, which distinguishes an edge-triggered match from a level match.

// File: rtl/disp_irq_pkg.sv
// Shared constants and types for the display interrupt status controller.
// Assumes a 32-bit register word; offsets are byte addresses.
package disp_irq_pkg;
    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 8;
    localparam int NUM_CH        = 2;
    localparam int LINE_W        = 12;

    localparam logic [ADDR_W-1:0] ADDR_CTL  = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_INT  = 8'h04;
    localparam logic [ADDR_W-1:0] ADDR_LINE = 8'h08;

    localparam int CTL_ENABLE_BIT = 31;
    localparam int CTL_GAMMA_BIT  = 30;
    localparam int CTL_MAP_BIT    = 0;

    // Enables count down from EN_TOP_BIT, flags from FLAG_TOP_BIT,
    // one bit per source (channel 0, channel 1, then line match).
    localparam int EN_TOP_BIT   = 31;
    localparam int FLAG_TOP_BIT = 15;

    typedef struct packed {
        logic enable;
        logic gamma;
        logic map_sel;
    } ctl_bits_t;
endpackage

// File: rtl/disp_ctl_reg.sv
// Global control register: holds the timing enable, gamma enable and
// output map select bits. Assumes wr_sel is already decoded by address.
module disp_ctl_reg
    import disp_irq_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_sel,
    input  logic [DW-1:0] wdata,
    output ctl_bits_t     ctl
);
    ctl_bits_t ctl_q;
    logic      unused_wdata;

    assign unused_wdata = ^wdata;

    // Capture the three control bits on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_sel) begin
            ctl_q.enable  <= wdata[CTL_ENABLE_BIT];
            ctl_q.gamma   <= wdata[CTL_GAMMA_BIT];
            ctl_q.map_sel <= wdata[CTL_MAP_BIT];
        end
    end

    assign ctl = ctl_q;

    // R1
    ctl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (ctl.enable == $past(wdata[CTL_ENABLE_BIT]) &&
                    ctl.map_sel == $past(wdata[CTL_MAP_BIT])));
endmodule

// File: rtl/disp_line_match.sv
// Line-number register and compare: raises a one-cycle hit in the first
// cycle the incoming line count equals the programmed line number.
// Assumes line_count changes at most once per cycle.
module disp_line_match
    import disp_irq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LINE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_sel,
    input  logic [DW-1:0] wdata,
    input  logic [LW-1:0] line_count,
    output logic [LW-1:0] line_num,
    output logic          hit
);
    logic [LW-1:0] num_q;
    logic          same_now;
    logic          same_q;
    logic          unused_wdata;

    assign unused_wdata = ^wdata;

    // Hold the programmed line number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q <= '0;
        end else if (wr_sel) begin
            num_q <= wdata[LW-1:0];
        end
    end

    assign same_now = (line_count == num_q);

    // Remember whether the previous cycle already matched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            same_q <= 1'b0;
        end else begin
            same_q <= same_now;
        end
    end

    assign hit      = same_now && !same_q;
    assign line_num = num_q;

    // R7
    line_hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/disp_irq_status.sv
// Interrupt word: per-source enables, sticky flags cleared by writing 0,
// and a registered OR of the enabled flags. Set events win over clears.
// Assumes set_evt pulses are synchronous to clk.
module disp_irq_status
    import disp_irq_pkg::*;
#(
    parameter int DW      = DATA_W,
    parameter int NUM_SRC = NUM_CH + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_sel,
    input  logic [DW-1:0]      wdata,
    input  logic [NUM_SRC-1:0] set_evt,
    output logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] flag,
    output logic [DW-1:0]      word,
    output logic               irq
);
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] flag_q;
    logic               irq_q;
    logic               unused_wdata;

    assign unused_wdata = ^wdata;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int EB = EN_TOP_BIT - i;
        localparam int FB = FLAG_TOP_BIT - i;

        // Enable bit loads directly from its write-data position.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[i] <= 1'b0;
            end else if (wr_sel) begin
                en_q[i] <= wdata[EB];
            end
        end

        // Flag: write 0 clears, write 1 keeps, a set event always wins.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else begin
                flag_q[i] <= (wr_sel ? (flag_q[i] & wdata[FB]) : flag_q[i])
                             | set_evt[i];
            end
        end

        // R2 R4
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> flag[i]);

        // R3
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel && !wdata[FB] && !set_evt[i]) |=> !flag[i]);
    end

    // Register the masked OR to form the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(flag_q & en_q);
        end
    end

    // Assemble the readable view of enables and flags.
    always_comb begin
        word = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            word[EN_TOP_BIT - k]   = en_q[k];
            word[FLAG_TOP_BIT - k] = flag_q[k];
        end
    end

    assign en   = en_q;
    assign flag = flag_q;
    assign irq  = irq_q;
endmodule

// File: rtl/disp_irq_ctrl.sv
// Top of the display interrupt status controller: address decode, read
// mux and wiring of control, line-match and interrupt-word submodules.
// Assumes one access per cycle; reads are combinational.
module disp_irq_ctrl
    import disp_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_CH-1:0]   vblank_start,
    input  logic [LINE_W-1:0]   line_count,
    output logic                irq,
    output logic                tc_enable,
    output logic                tc_gamma_en,
    output logic                tc_map_sel
);
    localparam int NUM_SRC = NUM_CH + 1;

    ctl_bits_t           ctl;
    logic                wr_ctl, wr_int, wr_line;
    logic [LINE_W-1:0]   line_num;
    logic                line_hit;
    logic [NUM_SRC-1:0]  set_evt;
    logic [NUM_SRC-1:0]  int_en;
    logic [NUM_SRC-1:0]  int_flag;
    logic [DATA_W-1:0]   int_word;

    assign wr_ctl  = bus_wr_en && (bus_addr == ADDR_CTL);
    assign wr_int  = bus_wr_en && (bus_addr == ADDR_INT);
    assign wr_line = bus_wr_en && (bus_addr == ADDR_LINE);

    disp_ctl_reg #(.DW(DATA_W)) i_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_ctl),
        .wdata  (bus_wdata),
        .ctl    (ctl)
    );

    disp_line_match #(.DW(DATA_W), .LW(LINE_W)) i_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (wr_line),
        .wdata      (bus_wdata),
        .line_count (line_count),
        .line_num   (line_num),
        .hit        (line_hit)
    );

    assign set_evt = {line_hit, vblank_start};

    disp_irq_status #(.DW(DATA_W), .NUM_SRC(NUM_SRC)) i_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_int),
        .wdata   (bus_wdata),
        .set_evt (set_evt),
        .en      (int_en),
        .flag    (int_flag),
        .word    (int_word),
        .irq     (irq)
    );

    // Select the addressed word; anything unmapped reads zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTL: begin
                bus_rdata[CTL_ENABLE_BIT] = ctl.enable;
                bus_rdata[CTL_GAMMA_BIT]  = ctl.gamma;
                bus_rdata[CTL_MAP_BIT]    = ctl.map_sel;
            end
            ADDR_INT:  bus_rdata = int_word;
            ADDR_LINE: bus_rdata[LINE_W-1:0] = line_num;
            default:   bus_rdata = '0;
        endcase
    end

    assign tc_enable   = ctl.enable;
    assign tc_gamma_en = ctl.gamma;
    assign tc_map_sel  = ctl.map_sel;

    // R6
    zero_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_int && bus_wdata == '0 && set_evt == '0)
            |=> (int_en == '0 && int_flag == '0));

    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == '0) |=> !irq);
endmodule

// File: tb/test_disp_irq_ctrl.sv
module test_disp_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  vb = '0;
    logic [11:0] line_cnt = 12'hFFF;
    logic        irq, o_en, o_gam, o_map;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    disp_irq_ctrl i_disp_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en),
        .bus_wdata(wdata), .bus_rdata(rdata), .vblank_start(vb),
        .line_count(line_cnt), .irq(irq), .tc_enable(o_en),
        .tc_gamma_en(o_gam), .tc_map_sel(o_map)
    );

    // Behavioural reference model, updated on the same edges.
    logic [31:0] m_ctl;
    logic [2:0]  m_en, m_flag;
    logic [11:0] m_line;
    logic        m_prev, m_irq, m_hit;

    assign m_hit = (line_cnt == m_line) && !m_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl <= 0; m_en <= 0; m_flag <= 0; m_line <= 0;
            m_prev <= 0; m_irq <= 0;
        end else begin
            m_irq  <= |(m_flag & m_en);
            m_prev <= (line_cnt == m_line);
            if (wr_en && addr == 8'h00) m_ctl <= wdata & 32'hC000_0001;
            if (wr_en && addr == 8'h08) m_line <= wdata[11:0];
            if (wr_en && addr == 8'h04) begin
                m_en   <= {wdata[29], wdata[30], wdata[31]};
                m_flag <= (m_flag & {wdata[13], wdata[14], wdata[15]})
                          | {m_hit, vb};
            end else begin
                m_flag <= m_flag | {m_hit, vb};
            end
        end
    end

    function automatic logic [31:0] m_word(input logic [7:0] a);
        case (a)
            8'h00:   return m_ctl;
            8'h04:   return {m_en[0], m_en[1], m_en[2], 13'd0,
                             m_flag[0], m_flag[1], m_flag[2], 13'd0};
            8'h08:   return {20'd0, m_line};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare the design against the model every cycle.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(rdata === m_word(addr),
                (addr == 8'h04) ? "R3 int word vs model" :
                (addr == 8'h08) ? "R7 line word vs model" :
                (addr == 8'h00) ? "R1 ctl word vs model" : "R8 unmapped vs model",
                rdata, m_word(addr));
            chk(irq === m_irq, "R5 irq vs model", {31'd0, irq}, {31'd0, m_irq});
            chk({o_en, o_gam, o_map} === {m_ctl[31], m_ctl[30], m_ctl[0]},
                "R1 control pins vs model", {29'd0, o_en, o_gam, o_map},
                {29'd0, m_ctl[31], m_ctl[30], m_ctl[0]});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        addr = a;
        #1 chk(rdata === exp, tag, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse(input logic [1:0] v);
        @(negedge clk); #1 vb = v;
        @(negedge clk); #1 vb = 2'b00;
    endtask

    task automatic ramp(input int lo, input int hi);
        for (int v = lo; v <= hi; v++) begin
            @(negedge clk); #1 line_cnt = v[11:0];
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        chk(irq === exp, tag, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin
        @(negedge clk); cmp_on = 1;
        wdata = 32'hFFFF_FFFF;
        wr_en = 1'b1;
        idle(2);
        // R8: reset holds everything at zero even with a write strobe
        rd(8'h00, 32'h0, "R8 reset ctl");
        rd(8'h04, 32'h0, "R8 reset int");
        rd(8'h08, 32'h0, "R8 reset line");
        chk_irq(1'b0, "R8 reset irq");
        wr_en = 1'b0;
        @(negedge clk); #1 rst_n = 1'b1;

        // R1: only bits 31, 30, 0 are stored
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'hC000_0001, "R1 ctl readback");
        chk({o_en, o_gam, o_map} === 3'b111, "R1 ctl pins", {29'd0, o_en, o_gam, o_map}, 32'd7);
        wr(8'h00, 32'h4000_0000);
        rd(8'h00, 32'h4000_0000, "R1 ctl partial");

        // R2: flag sets with enable off; no interrupt
        pulse(2'b01);
        rd(8'h04, 32'h0000_8000, "R2 ch0 flag sets");
        idle(2);
        chk_irq(1'b0, "R5 irq low while disabled");

        // R3/R5: enable with flag kept by writing 1
        wr(8'h04, 32'h8000_8000);
        rd(8'h04, 32'h8000_8000, "R3 write 1 keeps flag");
        idle(1);
        chk_irq(1'b1, "R5 irq after enable");

        // R3: write 0 clears the flag
        wr(8'h04, 32'h8000_0000);
        rd(8'h04, 32'h8000_0000, "R3 write 0 clears flag");
        idle(1);
        chk_irq(1'b0, "R5 irq drops after clear");

        // R4: set and clear in the same cycle
        @(negedge clk); #1;
        vb = 2'b10; addr = 8'h04; wdata = 32'h4000_0000; wr_en = 1'b1;
        @(negedge clk); #1;
        vb = 2'b00; wr_en = 1'b0;
        rd(8'h04, 32'h4000_4000, "R4 set wins over clear");
        idle(1);
        chk_irq(1'b1, "R5 irq from channel 1");

        // R6: zero write disables everything
        wr(8'h04, 32'h0);
        rd(8'h04, 32'h0, "R6 zero write clears word");
        idle(1);
        chk_irq(1'b0, "R6 irq low after zero write");
        pulse(2'b11);
        rd(8'h04, 32'h0000_C000, "R2 both flags set");
        idle(2);
        chk_irq(1'b0, "R6 irq stays low with flags set");
        wr(8'h04, 32'h0);

        // R7: line match on the programmed line
        wr(8'h08, 32'hFFFF_F005);
        rd(8'h08, 32'h0000_0005, "R7 line number readback");
        ramp(0, 9);
        rd(8'h04, 32'h0000_2000, "R7 line flag set");
        wr(8'h04, 32'h2000_0000);
        ramp(0, 5);
        idle(3);
        wr(8'h04, 32'h2000_0000);
        idle(3);
        rd(8'h04, 32'h2000_0000, "R7 no retrigger while held");
        chk_irq(1'b0, "R7 irq low while held");
        ramp(6, 6);
        ramp(5, 5);
        idle(1);
        rd(8'h04, 32'h2000_2000, "R7 re-entry sets flag");
        idle(1);
        chk_irq(1'b1, "R5 irq from line match");

        // R8: unmapped address reads zero, writes there change nothing
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0, "R8 unmapped reads zero");
        rd(8'h00, 32'h4000_0000, "R8 unmapped write no effect");

        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule